// File: doc/BRIEF.md
# Packed Decimal Pack/Unpack Converter

This block converts a stream of bytes between two forms of a decimal number. In the packed form each byte carries two BCD digits. In the character form each byte carries one ASCII digit, which is the digit value plus 0x30. A one-bit mode input picks the direction of the conversion. One length input sets the size of both operands: the character operand is always twice as long as the packed operand.

A job begins when `start` is pulsed while the block is idle. Source bytes are then taken from a valid/ready input stream, and result bytes are given out on a valid/ready output stream. Both streams may stall at any cycle. When the last result byte has been taken, the block pulses `done` for one cycle and becomes idle again. If a source digit is malformed, a sticky error flag is raised, but conversion of the job still runs to the end.

Top module: `decpack_conv`

## Requirements
- R1: In unpack mode (`mode`=0), each packed byte gives two characters. The first is 0x30 plus bits [7:4] and the second is 0x30 plus bits [3:0].
- R2: In pack mode (`mode`=1), two successive characters give one byte. Bits [3:0] of the first character go to bits [7:4] of the byte, and bits [3:0] of the second character go to bits [3:0].
- R3: `len_m1` is the packed operand length minus one; call that length P = `len_m1`+1. Unpack takes exactly P input bytes and produces 2P output bytes. Pack takes exactly 2P input bytes and produces P output bytes.
- R4: `data_err` becomes 1 when an accepted packed byte has a nibble above 9 (unpack mode), or when an accepted character is outside 0x30..0x39 (pack mode). It stays at 1 until the next accepted `start`. The job still produces every output byte using the R1/R2 rules, for example 0x30+0xC = 0x3C.
- R5: `done` is high for exactly one cycle. That cycle follows the clock edge at which the last output byte was accepted, and in that cycle `busy` is already 0.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays at 1 and `out_data` does not change. `in_ready` is 0 whenever `busy` is 0.
- R7: A `start` pulse while `busy` is 1 is ignored: the job in progress keeps its mode, its length and its output sequence.
- R8: After reset, `busy`, `in_ready`, `out_valid`, `done` and `data_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job (taken only when idle) |
| mode | input | 1 | 0 = unpack, 1 = pack; sampled with start |
| len_m1 | input | LEN_W | Packed length minus one; sampled with start |
| busy | output | 1 | A job is in progress |
| in_valid | input | 1 | Source byte valid |
| in_ready | output | 1 | Source byte can be taken |
| in_data | input | 8 | Source byte |
| out_valid | output | 1 | Result byte valid |
| out_ready | input | 1 | Downstream takes the result byte |
| out_data | output | 8 | Result byte |
| done | output | 1 | One-cycle pulse after the last result byte is taken |
| data_err | output | 1 | Sticky malformed-digit flag |

## Verification
The hardest case to reach is the unpack path when the output slot is full and the second nibble of a byte is still waiting to go out. In this case the next source byte must stall, while an output byte is produced with no input transfer. To reach it, the stimulus lowers `out_ready` at random, and separately lowers `in_valid` at random, on every cycle. It also runs jobs at the shortest and the longest length. Random data with occasional bad digits is mixed in, so that jobs with errors are followed by clean jobs that must clear the flag. A directed job pulses `start` with the opposite mode in the middle of a transfer.

// File: rtl/decpack_pkg.sv
package decpack_pkg;

    localparam logic [7:0] CHAR_ZONE = 8'h30;

    typedef enum logic {
        CONV_UNPACK = 1'b0,
        CONV_PACK   = 1'b1
    } conv_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } conv_state_e;

    typedef struct packed {
        logic       vld;
        logic [7:0] data;
    } out_slot_t;

    typedef struct packed {
        logic [7:0] emit;
        logic [3:0] hold_nxt;
        logic       bad;
    } lane_res_t;

    function automatic logic nib_is_digit(input logic [3:0] n);
        return n <= 4'd9;
    endfunction

    function automatic logic char_is_digit(input logic [7:0] c);
        return (c >= CHAR_ZONE) && (c <= CHAR_ZONE + 8'd9);
    endfunction

    function automatic logic [7:0] nib_to_char(input logic [3:0] n);
        return CHAR_ZONE + {4'h0, n};
    endfunction

endpackage

// File: rtl/decpack_ctr.sv
module decpack_ctr #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         nonzero,
    output logic         last
);
    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (dec)  cnt <= cnt - 1'b1;
    end

    assign nonzero = (cnt != '0);
    assign last    = (cnt == W'(1));

    // R3
    ctr_no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (dec && !load) |-> (cnt != '0));
endmodule

// File: rtl/decpack_lane.sv
module decpack_lane
    import decpack_pkg::*;
(
    input  conv_mode_e mode,
    input  logic       phase,
    input  logic [7:0] in_byte,
    input  logic [3:0] hold,
    output lane_res_t  res
);
    always_comb begin
        res = '0;
        if (mode == CONV_UNPACK) begin
            if (!phase) begin
                res.emit     = nib_to_char(in_byte[7:4]);
                res.hold_nxt = in_byte[3:0];
                res.bad      = !nib_is_digit(in_byte[7:4]) || !nib_is_digit(in_byte[3:0]);
            end else begin
                res.emit     = nib_to_char(hold);
                res.hold_nxt = hold;
                res.bad      = 1'b0;
            end
        end else begin
            res.hold_nxt = phase ? hold : in_byte[3:0];
            res.emit     = {hold, in_byte[3:0]};
            res.bad      = !char_is_digit(in_byte);
        end
    end
endmodule

// File: rtl/decpack_conv.sv
module decpack_conv
    import decpack_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             mode,
    input  logic [LEN_W-1:0] len_m1,
    output logic             busy,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             done,
    output logic             data_err
);
    localparam int CW = LEN_W + 2;

    conv_state_e state;
    conv_mode_e  mode_q;
    logic        phase;
    logic [3:0]  hold;
    out_slot_t   slot;
    lane_res_t   lres;

    logic          run, slot_free, out_fire, in_fire, take_start, slot_load, phase_flip;
    logic [CW-1:0] plen, in_total;
    logic [CW-1:0] in_cnt, out_cnt;
    logic          in_nz, out_nz, in_last, out_last;

    assign run        = (state == ST_RUN);
    assign take_start = start && !run;
    assign slot_free  = !slot.vld || out_ready;
    assign out_fire   = slot.vld && out_ready;

    assign plen     = CW'(len_m1) + CW'(1);
    assign in_total = (conv_mode_e'(mode) == CONV_PACK) ? (plen << 1) : plen;

    always_comb begin
        if (mode_q == CONV_UNPACK)
            in_ready = run && !phase && in_nz && slot_free;
        else
            in_ready = run && ((!phase && in_nz) || (phase && slot_free));
    end
    assign in_fire = in_valid && in_ready;

    always_comb begin
        if (mode_q == CONV_UNPACK) begin
            slot_load  = in_fire || (run && phase && slot_free);
            phase_flip = slot_load;
        end else begin
            slot_load  = in_fire && phase;
            phase_flip = in_fire;
        end
    end

    decpack_lane u_lane (
        .mode    (mode_q),
        .phase   (phase),
        .in_byte (in_data),
        .hold    (hold),
        .res     (lres)
    );

    decpack_ctr #(.W(CW)) u_in_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (take_start),
        .load_val (in_total),
        .dec      (in_fire),
        .cnt      (in_cnt),
        .nonzero  (in_nz),
        .last     (in_last)
    );

    decpack_ctr #(.W(CW)) u_out_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (take_start),
        .load_val ((conv_mode_e'(mode) == CONV_PACK) ? plen : (plen << 1)),
        .dec      (out_fire),
        .cnt      (out_cnt),
        .nonzero  (out_nz),
        .last     (out_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            mode_q   <= CONV_UNPACK;
            phase    <= 1'b0;
            hold     <= '0;
            slot     <= '0;
            done     <= 1'b0;
            data_err <= 1'b0;
        end else begin
            done <= 1'b0;
            if (take_start) begin
                state    <= ST_RUN;
                mode_q   <= conv_mode_e'(mode);
                phase    <= 1'b0;
                data_err <= 1'b0;
            end else if (run) begin
                if (phase_flip) phase <= !phase;
                if (in_fire && !phase) hold <= lres.hold_nxt;
                if (in_fire && lres.bad) data_err <= 1'b1;
                if (out_fire && out_last) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
            end
            if (slot_load) begin
                slot.vld  <= 1'b1;
                slot.data <= lres.emit;
            end else if (out_fire) begin
                slot.vld <= 1'b0;
            end
        end
    end

    assign busy      = run;
    assign out_valid = slot.vld;
    assign out_data  = slot.data;

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R4
    err_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(data_err) |-> $past(in_valid && busy));
    // R3
    in_drained_chk: assert property (@(posedge clk) disable iff (rst)
        (out_fire && out_last) |-> !in_nz);
endmodule

// File: tb/sim_decpack_conv.sv
module sim_decpack_conv;
    localparam int LEN_W = 4;

    logic clk = 1'b0;
    logic rst, start, mode, in_valid, out_ready;
    logic [LEN_W-1:0] len_m1;
    logic [7:0] in_data;
    logic busy, in_ready, out_valid, done, data_err;
    logic [7:0] out_data;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] src [64];
    logic [7:0] expv [64];

    always #2 clk = ~clk;

    decpack_conv #(.LEN_W(LEN_W)) u0 (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .len_m1(len_m1),
        .busy(busy), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .done(done), .data_err(data_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    function automatic logic [7:0] dig_char(input logic [3:0] n);
        return 8'h30 + {4'h0, n};
    endfunction

    // m: 0 unpack, 1 pack; bad_rate: chance (out of 16) of a malformed digit
    task automatic run_op(input logic m, input int len, input int bad_rate,
                          input bit stall, input bit late_start);
        int p = len + 1;
        int nin = m ? 2 * p : p;
        int nout = m ? p : 2 * p;
        logic exp_err = 1'b0;
        int ii = 0;
        int oi = 0;
        int cyc = 0;
        for (int k = 0; k < nin; k++) begin
            logic [3:0] hi = 4'($urandom_range(0, 9));
            logic [3:0] lo = 4'($urandom_range(0, 9));
            if (m == 1'b0) begin
                if (int'($urandom_range(0, 15)) < bad_rate) begin
                    hi = 4'($urandom_range(10, 15));
                    exp_err = 1'b1;
                end
                src[k] = {hi, lo};
                expv[2*k]   = dig_char(hi);
                expv[2*k+1] = dig_char(lo);
            end else begin
                src[k] = dig_char(lo);
                if (int'($urandom_range(0, 15)) < bad_rate) begin
                    src[k] = {4'($urandom_range(0, 15)) ^ 4'h3 | 4'h4, lo};
                    exp_err = 1'b1;
                end
            end
        end
        if (m == 1'b1)
            for (int k = 0; k < p; k++) expv[k] = {src[2*k][3:0], src[2*k+1][3:0]};

        @(negedge clk);
        start = 1'b1; mode = m; len_m1 = LEN_W'(len);
        @(negedge clk);
        start = 1'b0;
        while (oi < nout && cyc < 2000) begin
            cyc++;
            in_valid  = (ii < nin) && (!stall || ($urandom_range(0, 3) != 0));
            in_data   = src[ii < nin ? ii : 0];
            out_ready = !stall || ($urandom_range(0, 2) != 0);
            if (late_start && cyc == 3) begin
                start = 1'b1; mode = ~m; len_m1 = '0;
            end else begin
                start = 1'b0;
            end
            #1;
            if (in_valid && in_ready) ii++;
            if (out_valid && out_ready) begin
                check(m ? "R2 pack byte" : "R1 unpack char", 32'(out_data), 32'(expv[oi]));
                oi++;
            end
            if (oi < nout) @(negedge clk);
        end
        check("R3 input count", 32'(ii), 32'(nin));
        @(negedge clk);
        start = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        #1;
        check("R5 done pulse", 32'(done), 32'd1);
        check("R5 idle at done", 32'(busy), 32'd0);
        check("R4 error flag", 32'(data_err), 32'(exp_err));
        check("R6 no intake when idle", 32'(in_ready), 32'd0);
        @(negedge clk);
        check("R5 done one cycle", 32'(done), 32'd0);
        check("R3 no extra output", 32'(out_valid), 32'd0);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; start = 1'b0; mode = 1'b0; len_m1 = '0;
        in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R8 reset state
        check("R8 busy", 32'(busy), 32'd0);
        check("R8 in_ready", 32'(in_ready), 32'd0);
        check("R8 out_valid", 32'(out_valid), 32'd0);
        check("R8 done", 32'(done), 32'd0);
        check("R8 data_err", 32'(data_err), 32'd0);

        // R3 shortest and longest, both modes
        run_op(1'b0, 0, 0, 1'b0, 1'b0);
        run_op(1'b1, 0, 0, 1'b0, 1'b0);
        run_op(1'b0, 15, 0, 1'b1, 1'b0);
        run_op(1'b1, 15, 0, 1'b1, 1'b0);
        // R4 forced errors, then clean jobs that must clear the flag
        run_op(1'b0, 3, 16, 1'b1, 1'b0);
        run_op(1'b0, 3, 0, 1'b1, 1'b0);
        run_op(1'b1, 3, 16, 1'b1, 1'b0);
        run_op(1'b1, 2, 0, 1'b0, 1'b0);
        // R7 start pulsed mid-job with other mode and length
        run_op(1'b0, 5, 0, 1'b1, 1'b1);
        run_op(1'b1, 5, 0, 1'b1, 1'b1);
        // R6 backpressure heavy random mix
        for (int t = 0; t < 60; t++)
            run_op(1'($urandom_range(0, 1)), int'($urandom_range(0, 15)), 1, 1'b1, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule